// File: doc/BRIEF.md
# One-Hot Coin Accumulator for a Fixed-Price Dispenser

This controller tracks the credit inserted into a dispenser that sells one item at a fixed price, 15 cents with the default parameters. A coin sensor delivers single-cycle, clock-synchronous pulses: one for a 5-cent coin and one for a 10-cent coin. No other coins are accepted. The controller raises a release output once the credit reaches the price. It gives no change, so any overpayment is simply kept.

The credit is held in a one-hot register, with one flip-flop for each credit level in 5-cent steps. Each bit's next value is the OR of one product term for each arc that enters that level. The accept level is absorbing. Only a synchronous, active-high reset leaves it, and that reset returns the machine to the zero-credit level. If both coin inputs are high in the same cycle, the input is treated as invalid and the credit holds.

The block is built as three parts under a thin top:
- a control part that turns the coin pulses into move strobes;
- a state part that holds the one-hot register;
- a package for the shared strobe type.

The price is a parameter, given in 5-cent steps.

Top module: `coin_vend_top`

## Requirements
- R1: A high `rst` at a rising clock edge sets `creditLevel` to the zero level, encoded with only bit 0 set (0001 by default), and `vendOpen` low, whatever the coin inputs are.
- R2: Away from reset, exactly one bit of `creditLevel` is set at every clock edge. Bit k set means a credit of 5·k cents.
- R3: A cycle with `nickelIn` high and `dimeIn` low moves the credit up by one level at the next edge.
- R4: A cycle with `dimeIn` high and `nickelIn` low moves the credit up by two levels at the next edge. The credit saturates at the accept level, so a 10-cent coin at one step below the price also reaches the accept level.
- R5: A cycle with neither coin input high leaves `creditLevel` unchanged.
- R6: A cycle with both coin inputs high leaves `creditLevel` unchanged.
- R7: `vendOpen` is high exactly when the top bit of `creditLevel` (the accept level, 15 cents by default) is set.
- R8: Once the accept level is reached, any further coins leave `creditLevel` and `vendOpen` unchanged until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to zero credit |
| nickelIn | input | 1 | Single-cycle pulse for a 5-cent coin |
| dimeIn | input | 1 | Single-cycle pulse for a 10-cent coin |
| vendOpen | output | 1 | High while the release mechanism should open |
| creditLevel | output | PRICE_STEPS+1 | One-hot credit register, bit k means 5·k cents |

## Verification
The bench builds the block with the default price of three steps, giving four one-hot levels. That size reaches every arc:
- both 5-cent and 10-cent moves from the lower levels;
- a 10-cent coin saturating from 10 cents into the accept level;
- the accept level absorbing further coins.

A behavioural credit counter predicts the register for each cycle. This includes invalid double-coin cycles issued at several levels, and resets that arrive partway through a purchase.

// File: rtl/coin_vend_pkg.sv
package coin_vend_pkg;

  // Move strobes sent from the control part to the state part
  typedef struct packed {
    logic hold;     // keep current level
    logic stepOne;  // advance one level (5 cents)
    logic stepTwo;  // advance two levels (10 cents)
  } moveStrobe_t;

endpackage

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import coin_vend_pkg::*;
(
  input  logic        nickelIn,
  input  logic        dimeIn,
  output moveStrobe_t moveStb
);

  logic onlyNickel;
  logic onlyDime;

  // A simultaneous pair is invalid and falls through to hold
  assign onlyNickel = nickelIn & ~dimeIn;
  assign onlyDime   = dimeIn & ~nickelIn;

  always_comb begin
    moveStb.stepOne = onlyNickel;
    moveStb.stepTwo = onlyDime;
    moveStb.hold    = ~(onlyNickel | onlyDime);
  end

endmodule

// File: rtl/coin_vend_state.sv
module coin_vend_state
  import coin_vend_pkg::*;
#(
  parameter int STATE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  moveStrobe_t        moveStb,
  output logic [STATE_W-1:0] levelQ
);

  localparam int TOP = STATE_W - 1;

  logic [STATE_W-1:0] levelD;

  // One product term per incoming arc, per bit
  for (genvar k = 0; k < STATE_W; k++) begin : g_bit
    logic fromHold;
    logic fromOne;
    logic fromTwo;

    if (k == TOP) begin : g_hold_top
      assign fromHold = levelQ[k];
    end else begin : g_hold_mid
      assign fromHold = levelQ[k] & moveStb.hold;
    end

    if (k == 0) begin : g_one_none
      assign fromOne = 1'b0;
    end else if (k == TOP) begin : g_one_sat
      assign fromOne = levelQ[k-1] & (moveStb.stepOne | moveStb.stepTwo);
    end else begin : g_one_mid
      assign fromOne = levelQ[k-1] & moveStb.stepOne;
    end

    if (k >= 2) begin : g_two_arc
      assign fromTwo = levelQ[k-2] & moveStb.stepTwo;
    end else begin : g_two_none
      assign fromTwo = 1'b0;
    end

    assign levelD[k] = fromHold | fromOne | fromTwo;
  end

  always_ff @(posedge clk) begin
    if (rst) levelQ <= STATE_W'(1);
    else     levelQ <= levelD;
  end

endmodule

// File: rtl/coin_vend_top.sv
module coin_vend_top
  import coin_vend_pkg::*;
#(
  parameter int PRICE_STEPS = 3,
  localparam int STATE_W = PRICE_STEPS + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               nickelIn,
  input  logic               dimeIn,
  output logic               vendOpen,
  output logic [STATE_W-1:0] creditLevel
);

  moveStrobe_t        moveStb;
  logic [STATE_W-1:0] levelQ;

  coin_vend_ctrl ctrl_i (
    .nickelIn (nickelIn),
    .dimeIn   (dimeIn),
    .moveStb  (moveStb)
  );

  coin_vend_state #(.STATE_W(STATE_W)) state_i (
    .clk     (clk),
    .rst     (rst),
    .moveStb (moveStb),
    .levelQ  (levelQ)
  );

  // Output encoding: the accept flip-flop drives the release directly
  assign vendOpen    = levelQ[STATE_W-1];
  assign creditLevel = levelQ;

endmodule

// File: rtl/coin_vend_chk.sv
module coin_vend_chk #(
  parameter int STATE_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               nickelIn,
  input logic               dimeIn,
  input logic               vendOpen,
  input logic [STATE_W-1:0] creditLevel
);

  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (creditLevel == STATE_W'(1)) && !vendOpen);

  a_r2_one_hot: assert property (@(posedge clk) disable iff (rst)
    $countones(creditLevel) == 1);

  a_r3_nickel_from_zero: assert property (@(posedge clk) disable iff (rst)
    (creditLevel[0] && nickelIn && !dimeIn) |=> creditLevel[1]);

  a_r4_dime_saturates: assert property (@(posedge clk) disable iff (rst)
    (creditLevel[STATE_W-2] && dimeIn && !nickelIn) |=> vendOpen);

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!nickelIn && !dimeIn) |=> $stable(creditLevel));

  a_r6_pair_holds: assert property (@(posedge clk) disable iff (rst)
    (nickelIn && dimeIn) |=> $stable(creditLevel));

  a_r8_absorbing: assert property (@(posedge clk) disable iff (rst)
    vendOpen |=> vendOpen && $stable(creditLevel));

endmodule

bind coin_vend_top coin_vend_chk #(.STATE_W(STATE_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .nickelIn    (nickelIn),
  .dimeIn      (dimeIn),
  .vendOpen    (vendOpen),
  .creditLevel (creditLevel)
);

// File: tb/coin_vend_top_tb_top.sv
`timescale 1ns/1ps
module coin_vend_top_tb_top;

  localparam int PRICE_STEPS = 3;
  localparam int STATE_W     = PRICE_STEPS + 1;

  typedef struct {
    logic [STATE_W-1:0] level;
    logic               open;
    string              tag;
  } expItem_t;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               nickelIn = 1'b0;
  logic               dimeIn = 1'b0;
  logic               vendOpen;
  logic [STATE_W-1:0] creditLevel;

  expItem_t expQ[$];
  int  nApplied = 0;
  int  nFail    = 0;
  int  modelLvl = 0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  coin_vend_top #(.PRICE_STEPS(PRICE_STEPS)) dut_i (
    .clk         (clk),
    .rst         (rst),
    .nickelIn    (nickelIn),
    .dimeIn      (dimeIn),
    .vendOpen    (vendOpen),
    .creditLevel (creditLevel)
  );

  // Driver: one cycle of stimulus, expected result pushed to the queue
  task automatic drive(input logic r, input logic n, input logic d, input string tag);
    expItem_t it;
    @(negedge clk);
    rst = r; nickelIn = n; dimeIn = d;
    if (r) modelLvl = 0;
    else if (modelLvl == PRICE_STEPS) modelLvl = PRICE_STEPS;
    else if (n && !d) modelLvl = modelLvl + 1;
    else if (d && !n) modelLvl = (modelLvl + 2 > PRICE_STEPS) ? PRICE_STEPS : modelLvl + 2;
    it.level = STATE_W'(1) << modelLvl;
    it.open  = (modelLvl == PRICE_STEPS);
    it.tag   = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compare just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        nApplied++;
        if (creditLevel !== e.level || vendOpen !== e.open) begin
          nFail++;
          $display("FAIL %s: level=%b open=%b expected level=%b open=%b",
                   e.tag, creditLevel, vendOpen, e.level, e.open);
        end
        if ($countones(creditLevel) != 1) begin
          nFail++;
          $display("FAIL R2: level=%b ones=%0d expected ones=1",
                   creditLevel, $countones(creditLevel));
        end
      end
    end
  end

  initial begin
    #80000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nApplied, nFail);
      $finish;
    end
  end

  initial begin
    drive(1, 1, 1, "R1 reset with coins high");
    drive(0, 0, 0, "R5 idle at zero");
    drive(0, 1, 1, "R6 pair at zero");
    drive(0, 1, 0, "R3 nickel 0->5");
    drive(0, 1, 1, "R6 pair at five");
    drive(0, 0, 0, "R5 idle at five");
    drive(0, 1, 0, "R3 nickel 5->10");
    drive(0, 1, 1, "R6 pair at ten");
    drive(0, 1, 0, "R7 nickel 10->15 opens");
    drive(0, 1, 0, "R8 nickel absorbed");
    drive(0, 0, 1, "R8 dime absorbed");
    drive(0, 1, 1, "R8 pair absorbed");
    drive(0, 0, 0, "R8 idle at accept");
    drive(1, 0, 0, "R1 reset from accept");
    drive(0, 0, 1, "R4 dime 0->10");
    drive(0, 0, 1, "R4 dime 10 saturates");
    drive(1, 0, 0, "R1 reset");
    drive(0, 1, 0, "R3 nickel 0->5");
    drive(0, 0, 1, "R4 dime 5->15");
    drive(0, 0, 0, "R7 open holds");
    drive(1, 0, 1, "R1 reset with dime");
    drive(0, 0, 1, "R4 dime 0->10");
    drive(0, 1, 0, "R7 nickel 10->15");
    drive(1, 0, 0, "R1 reset");
    drive(0, 1, 0, "R3 nickel 0->5");
    drive(1, 1, 0, "R1 reset mid purchase");
    drive(0, 0, 0, "R5 idle after reset");
    for (int i = 0; i < 20; i++) begin
      drive(0, (i % 3) == 0, (i % 5) == 1, "R2 mixed stream");
    end
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nApplied, nFail);
    $finish;
  end

endmodule